// File: doc/BRIEF.md
# SD Card Data Word FIFO with Status and Interrupt Flags

This block buffers 32-bit data words between a processor bus and the serializer that drives the SD card data lines. One direction is active at a time. In receive mode the serializer pushes words and the bus pops them. In transmit mode the bus pushes words and the serializer pops them. Strobes that belong to the inactive direction are ignored.

A 32-bit status word reports the occupancy as a byte count, together with ready, half-level, pending and error flags. A flag for "last receive data ready" is set by the serializer at the end of a transfer and is cleared when software writes 1 to it. A status write with the flush bit set empties the FIFO. Three interrupt sources can each be enabled on their own: receive half full, last data ready, and transmit half empty. The enabled sources are ORed into a single request line.

Top module: `sd_word_fifo`

## Requirements
- R1: Status bits [6:0] hold four times the number of stored words (a byte count, 0 to 64). After reset, with receive mode selected, the whole status word reads 0.
- R2: Status bit 7 is 1 exactly when receive mode is selected and at least 8 words are stored.
- R3: Status bit 12 is 1 when receive mode is selected and at least one word is stored. Status bit 13 is 1 when transmit mode is selected and fewer than 16 words are stored.
- R4: Status bit 9 sets one cycle after a pulse on `xfer_end_i` in receive mode and then holds. It clears after a status write with data bit 9 = 1. A status write with data bit 9 = 0 leaves it unchanged.
- R5: Status bit 10 is 1 when transmit mode is selected and at least one word is still stored.
- R6: A status write with data bit 16 = 1 empties the FIFO and clears status bits 14 and 15 by the next cycle.
- R7: Status bit 8 (transmit half empty) is 1 when transmit mode is selected and 8 or fewer words are stored. `irq_o` = (bit7 & mask[0]) | (bit9 & mask[1]) | (bit8 & mask[2]).
- R8: Words leave in the order they entered. The oldest word is presented on both `bus_rd_data_o` and `ser_pop_data_o` before it is popped.
- R9: A push into a full FIFO is dropped and sets sticky status bit 14. A pop from an empty FIFO is dropped and sets sticky status bit 15.
- R10: In receive mode `bus_wr_en_i` and `ser_pop_i` have no effect. In transmit mode `ser_push_i`, `bus_rd_en_i` and `xfer_end_i` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dir_tx_i | input | 1 | 1 selects transmit mode, 0 selects receive mode |
| bus_wr_en_i | input | 1 | Bus pushes a word (transmit mode) |
| bus_wr_data_i | input | 32 | Word pushed by the bus |
| bus_rd_en_i | input | 1 | Bus pops a word (receive mode) |
| bus_rd_data_o | output | 32 | Oldest stored word, as seen by the bus |
| ser_push_i | input | 1 | Serializer pushes a word (receive mode) |
| ser_push_data_i | input | 32 | Word pushed by the serializer |
| ser_pop_i | input | 1 | Serializer pops a word (transmit mode) |
| ser_pop_data_o | output | 32 | Oldest stored word, as seen by the serializer |
| xfer_end_i | input | 1 | End-of-transfer pulse from the serializer |
| stat_wr_en_i | input | 1 | Write strobe for the status word |
| stat_wr_data_i | input | 32 | Status write data: bit 9 clears last-data, bit 16 flushes |
| int_mask_i | input | 3 | Interrupt enables: [0] rx half full, [1] last data, [2] tx half empty |
| status_o | output | 32 | Status word |
| irq_o | output | 1 | Interrupt request |

## Verification
Every push, pop, end-of-transfer pulse and status write is captured at one rising edge. Its effect on the byte count, the flags and the head word is visible right after that edge. The interrupt line follows in the same cycle, because it is combinational from registered state. The bench drives each stimulus on a falling edge, removes it on the next falling edge, and samples there, exactly one rising edge later. Checks that a strobe was ignored read the byte count and flags in that same sample, before any further stimulus is applied.

// File: rtl/sdf_pkg.sv
// Package: shared status-word layout and interrupt source indices for the
// SD data word FIFO. Assumes a 32-bit status word with a 7-bit byte count.
package sdf_pkg;
    localparam int STAT_W     = 32;
    localparam int BYTE_W     = 7;   // byte count field [6:0]
    localparam int ST_RXHALF  = 7;
    localparam int ST_TXHE    = 8;
    localparam int ST_LAST    = 9;
    localparam int ST_TXPEND  = 10;
    localparam int ST_RXAVAIL = 12;
    localparam int ST_TXRDY   = 13;
    localparam int ST_OVF     = 14;
    localparam int ST_UNF     = 15;
    localparam int CTL_FLUSH  = 16;  // write-only flush request bit
    localparam int IRQ_RXHALF = 0;
    localparam int IRQ_LAST   = 1;
    localparam int IRQ_TXHE   = 2;
    localparam int NUM_IRQ    = 3;
endpackage

// File: rtl/sdf_store.sv
// Module: circular word store with show-ahead head and word counter.
// Pushes into a full store and pops from an empty one are dropped and
// reported as one-cycle events. Flush returns pointers and count to zero.
// Assumes a DEPTH of at least 2.
module sdf_store #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 16,
    parameter int CNT_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              flush,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic [DATA_W-1:0] head,
    output logic [CNT_W-1:0]  words,
    output logic              ovf_evt,
    output logic              unf_evt
);
    localparam int AW = $clog2(DEPTH);
    localparam logic [AW-1:0]    LAST_IDX = AW'(DEPTH - 1);
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [AW-1:0]     wptr, rptr;
    logic              full, empty, push_ok, pop_ok;

    assign full    = (words == FULL_CNT);
    assign empty   = (words == '0);
    assign push_ok = push && !full;
    assign pop_ok  = pop && !empty;
    assign ovf_evt = push && full;
    assign unf_evt = pop && empty;
    assign head    = mem[rptr];

    // Purpose: write an accepted word into the slot at the write pointer.
    always_ff @(posedge clk) begin
        if (push_ok) mem[wptr] <= push_data;
    end

    // Purpose: advance the write pointer with wrap, or clear it.
    always_ff @(posedge clk) begin
        if (!rst_n || flush)  wptr <= '0;
        else if (push_ok)     wptr <= (wptr == LAST_IDX) ? '0 : wptr + 1'b1;
    end

    // Purpose: advance the read pointer with wrap, or clear it.
    always_ff @(posedge clk) begin
        if (!rst_n || flush)  rptr <= '0;
        else if (pop_ok)      rptr <= (rptr == LAST_IDX) ? '0 : rptr + 1'b1;
    end

    // Purpose: track the number of stored words.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) words <= '0;
        else begin
            case ({push_ok, pop_ok})
                2'b10:   words <= words + 1'b1;
                2'b01:   words <= words - 1'b1;
                default: words <= words;
            endcase
        end
    end
endmodule

// File: rtl/sdf_status.sv
// Module: builds the status word from occupancy and direction, and holds
// the last-data flag and the sticky overflow and underflow flags.
// Assumes DEPTH*4 fits in the 7-bit byte count field.
module sdf_status #(
    parameter int DEPTH = 16,
    parameter int CNT_W = 5
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      dir_tx,
    input  logic [CNT_W-1:0]          words,
    input  logic                      xfer_end,
    input  logic                      clr_last,
    input  logic                      flush,
    input  logic                      ovf_evt,
    input  logic                      unf_evt,
    output logic [sdf_pkg::STAT_W-1:0] status
);
    import sdf_pkg::*;
    localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);
    localparam logic [CNT_W-1:0] HALF_CNT = CNT_W'(DEPTH / 2);

    logic last_q, ovf_q, unf_q;

    // Purpose: last receive data flag, set by end of transfer, write-1 clear.
    always_ff @(posedge clk) begin
        if (!rst_n)                   last_q <= 1'b0;
        else if (xfer_end && !dir_tx) last_q <= 1'b1;
        else if (clr_last)            last_q <= 1'b0;
    end

    // Purpose: sticky error flags, cleared by reset or flush.
    always_ff @(posedge clk) begin
        if (!rst_n || flush) begin
            ovf_q <= 1'b0;
            unf_q <= 1'b0;
        end else begin
            if (ovf_evt) ovf_q <= 1'b1;
            if (unf_evt) unf_q <= 1'b1;
        end
    end

    // Purpose: assemble the status word.
    always_comb begin
        status             = '0;
        status[BYTE_W-1:0] = BYTE_W'({words, 2'b00});
        status[ST_RXHALF]  = !dir_tx && (words >= HALF_CNT);
        status[ST_TXHE]    = dir_tx && (words <= HALF_CNT);
        status[ST_LAST]    = last_q;
        status[ST_TXPEND]  = dir_tx && (words != '0);
        status[ST_RXAVAIL] = !dir_tx && (words != '0);
        status[ST_TXRDY]   = dir_tx && (words != FULL_CNT);
        status[ST_OVF]     = ovf_q;
        status[ST_UNF]     = unf_q;
    end
endmodule

// File: rtl/sdf_irq.sv
// Module: gates each interrupt source with its enable bit and ORs them.
// Assumes sources are already level flags.
module sdf_irq #(
    parameter int N = 3
) (
    input  logic [N-1:0] src,
    input  logic [N-1:0] mask,
    output logic         irq
);
    logic [N-1:0] gated;
    // Purpose: per-source enable gating.
    for (genvar i = 0; i < N; i++) begin : g_gate
        assign gated[i] = src[i] & mask[i];
    end
    assign irq = |gated;
endmodule

// File: rtl/sd_word_fifo.sv
// Module: SD data word FIFO top. Routes push and pop strobes by direction,
// decodes status writes, and exposes status and interrupt request.
// Assumes software changes direction only while the FIFO is idle.
module sd_word_fifo #(
    parameter int DATA_W = 32,
    parameter int DEPTH  = 16
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 dir_tx_i,
    input  logic                 bus_wr_en_i,
    input  logic [DATA_W-1:0]    bus_wr_data_i,
    input  logic                 bus_rd_en_i,
    output logic [DATA_W-1:0]    bus_rd_data_o,
    input  logic                 ser_push_i,
    input  logic [DATA_W-1:0]    ser_push_data_i,
    input  logic                 ser_pop_i,
    output logic [DATA_W-1:0]    ser_pop_data_o,
    input  logic                 xfer_end_i,
    input  logic                 stat_wr_en_i,
    input  logic [31:0]          stat_wr_data_i,
    input  logic [2:0]           int_mask_i,
    output logic [31:0]          status_o,
    output logic                 irq_o
);
    import sdf_pkg::*;
    localparam int CNT_W = $clog2(DEPTH + 1);

    logic              push, pop, flush, clr_last, ovf_evt, unf_evt;
    logic [DATA_W-1:0] push_data, head;
    logic [CNT_W-1:0]  words;
    logic [NUM_IRQ-1:0] irq_src;

    // Purpose: select the active producer and consumer by direction.
    always_comb begin
        push      = dir_tx_i ? bus_wr_en_i   : ser_push_i;
        push_data = dir_tx_i ? bus_wr_data_i : ser_push_data_i;
        pop       = dir_tx_i ? ser_pop_i     : bus_rd_en_i;
    end

    assign flush    = stat_wr_en_i && stat_wr_data_i[CTL_FLUSH];
    assign clr_last = stat_wr_en_i && stat_wr_data_i[ST_LAST];

    sdf_store #(.DATA_W(DATA_W), .DEPTH(DEPTH), .CNT_W(CNT_W)) store_i (
        .clk(clk), .rst_n(rst_n), .flush(flush),
        .push(push), .push_data(push_data), .pop(pop),
        .head(head), .words(words), .ovf_evt(ovf_evt), .unf_evt(unf_evt)
    );

    sdf_status #(.DEPTH(DEPTH), .CNT_W(CNT_W)) status_i (
        .clk(clk), .rst_n(rst_n), .dir_tx(dir_tx_i), .words(words),
        .xfer_end(xfer_end_i), .clr_last(clr_last), .flush(flush),
        .ovf_evt(ovf_evt), .unf_evt(unf_evt), .status(status_o)
    );

    assign irq_src[IRQ_RXHALF] = status_o[ST_RXHALF];
    assign irq_src[IRQ_LAST]   = status_o[ST_LAST];
    assign irq_src[IRQ_TXHE]   = status_o[ST_TXHE];

    sdf_irq #(.N(NUM_IRQ)) irq_i (
        .src(irq_src), .mask(int_mask_i), .irq(irq_o)
    );

    assign bus_rd_data_o  = head;
    assign ser_pop_data_o = head;
endmodule

// File: rtl/sd_word_fifo_chk.sv
// Module: assertion checker for the SD data word FIFO, bound to the top.
// Assumes the default depth of 16 words (64 bytes).
module sd_word_fifo_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        dir_tx_i,
    input logic        bus_wr_en_i,
    input logic        bus_rd_en_i,
    input logic        ser_push_i,
    input logic        ser_pop_i,
    input logic        xfer_end_i,
    input logic        stat_wr_en_i,
    input logic [31:0] stat_wr_data_i,
    input logic [2:0]  int_mask_i,
    input logic [31:0] status_o,
    input logic        irq_o
);
    localparam logic [6:0] FULL_BYTES = 7'd64;
    logic flush_w, clr_w;
    assign flush_w = stat_wr_en_i && stat_wr_data_i[16];
    assign clr_w   = stat_wr_en_i && stat_wr_data_i[9];

    p_count_limit_r1: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[6:0] <= FULL_BYTES);
    p_last_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[9] && !clr_w |=> status_o[9]);
    p_last_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        clr_w && !(xfer_end_i && !dir_tx_i) |=> !status_o[9]);
    p_flush_r6: assert property (@(posedge clk) disable iff (!rst_n)
        flush_w |=> (status_o[6:0] == 7'd0) && !status_o[14] && !status_o[15]);
    p_irq_source_r7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (status_o[7] && int_mask_i[0]) || (status_o[9] && int_mask_i[1])
                  || (status_o[8] && int_mask_i[2]));
    p_no_overflow_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !dir_tx_i && ser_push_i && (status_o[6:0] == FULL_BYTES) && !flush_w
        |=> status_o[14] && (status_o[6:0] == FULL_BYTES));
    p_ovf_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
        status_o[14] && !flush_w |=> status_o[14]);
    p_ignored_rx_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !dir_tx_i && !ser_push_i && !bus_rd_en_i && !flush_w
        && (bus_wr_en_i || ser_pop_i) |=> $stable(status_o[6:0]));
endmodule

bind sd_word_fifo sd_word_fifo_chk chk_i (
    .clk(clk), .rst_n(rst_n), .dir_tx_i(dir_tx_i),
    .bus_wr_en_i(bus_wr_en_i), .bus_rd_en_i(bus_rd_en_i),
    .ser_push_i(ser_push_i), .ser_pop_i(ser_pop_i), .xfer_end_i(xfer_end_i),
    .stat_wr_en_i(stat_wr_en_i), .stat_wr_data_i(stat_wr_data_i),
    .int_mask_i(int_mask_i), .status_o(status_o), .irq_o(irq_o)
);

// File: tb/sd_word_fifo_tb_top.sv
// Bench: vector table for basic push/pop traffic, then directed tests.
module sd_word_fifo_tb_top;
    localparam int CLK_NS = 10;
    localparam int NVEC = 10;
    // vector: {op[1:0], data[31:0], exp_bytes[6:0], exp_head[31:0]}
    // op 0 rx push, 1 rx pop, 2 tx push, 3 tx pop
    localparam logic [72:0] VECS [NVEC] = '{
        {2'd0, 32'hA1A1_0001, 7'd4,  32'hA1A1_0001},
        {2'd0, 32'hB2B2_0002, 7'd8,  32'hA1A1_0001},
        {2'd0, 32'hC3C3_0003, 7'd12, 32'hA1A1_0001},
        {2'd1, 32'h0,         7'd8,  32'hB2B2_0002},
        {2'd1, 32'h0,         7'd4,  32'hC3C3_0003},
        {2'd1, 32'h0,         7'd0,  32'h0},
        {2'd2, 32'hD4D4_0004, 7'd4,  32'hD4D4_0004},
        {2'd2, 32'hE5E5_0005, 7'd8,  32'hD4D4_0004},
        {2'd3, 32'h0,         7'd4,  32'hE5E5_0005},
        {2'd3, 32'h0,         7'd0,  32'h0}
    };

    logic clk = 1'b0, rst_n = 1'b0;
    logic dir_tx = 1'b0, bus_wr_en = 1'b0, bus_rd_en = 1'b0;
    logic ser_push = 1'b0, ser_pop = 1'b0, xfer_end = 1'b0, stat_wr_en = 1'b0;
    logic [31:0] bus_wr_data = '0, ser_push_data = '0, stat_wr_data = '0;
    logic [2:0]  int_mask = '0;
    logic [31:0] bus_rd_data, ser_pop_data, status;
    logic        irq;
    int n_chk = 0, n_bad = 0;

    always #(CLK_NS/2) clk = ~clk;

    sd_word_fifo dut_i (
        .clk(clk), .rst_n(rst_n), .dir_tx_i(dir_tx),
        .bus_wr_en_i(bus_wr_en), .bus_wr_data_i(bus_wr_data),
        .bus_rd_en_i(bus_rd_en), .bus_rd_data_o(bus_rd_data),
        .ser_push_i(ser_push), .ser_push_data_i(ser_push_data),
        .ser_pop_i(ser_pop), .ser_pop_data_o(ser_pop_data),
        .xfer_end_i(xfer_end), .stat_wr_en_i(stat_wr_en),
        .stat_wr_data_i(stat_wr_data), .int_mask_i(int_mask),
        .status_o(status), .irq_o(irq)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // One-cycle strobe: set on a falling edge, clear on the next one.
    task automatic strobe(input int kind, input logic [31:0] d);
        case (kind)
            0: begin ser_push = 1'b1; ser_push_data = d; end
            1: bus_rd_en = 1'b1;
            2: begin bus_wr_en = 1'b1; bus_wr_data = d; end
            3: ser_pop = 1'b1;
            4: xfer_end = 1'b1;
            default: begin stat_wr_en = 1'b1; stat_wr_data = d; end
        endcase
        @(negedge clk);
        {ser_push, bus_rd_en, bus_wr_en, ser_pop, xfer_end, stat_wr_en} = '0;
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin : main
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset status", status, 32'h0);
        chk("R7 reset irq", {31'b0, irq}, 32'h0);

        // Table walk: R1 byte count and R8 order/head.
        for (int v = 0; v < NVEC; v++) begin
            logic [1:0] op;
            op = VECS[v][72:71];
            dir_tx = op[1];
            strobe(int'(op), VECS[v][70:39]);
            chk($sformatf("R1 vec%0d bytes", v), {25'b0, status[6:0]}, {25'b0, VECS[v][38:32]});
            if (VECS[v][38:32] != 7'd0)
                chk($sformatf("R8 vec%0d head", v), op[1] ? ser_pop_data : bus_rd_data, VECS[v][31:0]);
        end

        // R2 / R3 / R7 receive half full
        dir_tx = 1'b0;
        for (int i = 0; i < 7; i++) strobe(0, 32'h100 + i);
        chk("R2 seven words no half", {31'b0, status[7]}, 32'h0);
        strobe(0, 32'h107);
        chk("R2 eight words half", {31'b0, status[7]}, 32'h1);
        chk("R1 eight words bytes", {25'b0, status[6:0]}, 32'd32);
        chk("R3 rx avail", {31'b0, status[12]}, 32'h1);
        chk("R3 tx ready off in rx", {31'b0, status[13]}, 32'h0);
        int_mask = 3'b001; #1;
        chk("R7 rx half irq enabled", {31'b0, irq}, 32'h1);
        int_mask = 3'b000; #1;
        chk("R7 rx half irq masked", {31'b0, irq}, 32'h0);

        // R10 inactive-direction strobes in receive mode
        strobe(2, 32'hBAD0_0001);
        chk("R10 bus write ignored in rx", {25'b0, status[6:0]}, 32'd32);
        strobe(3, 32'h0);
        chk("R10 ser pop ignored in rx", {25'b0, status[6:0]}, 32'd32);

        // R9 overflow
        for (int i = 8; i < 16; i++) strobe(0, 32'h100 + i);
        chk("R1 full bytes", {25'b0, status[6:0]}, 32'd64);
        strobe(0, 32'hDEAD_BEEF);
        chk("R9 overflow flag", {31'b0, status[14]}, 32'h1);
        chk("R9 overflow count kept", {25'b0, status[6:0]}, 32'd64);
        for (int i = 0; i < 16; i++) begin
            chk($sformatf("R8 order word %0d", i), bus_rd_data, 32'h100 + i);
            strobe(1, 32'h0);
        end
        chk("R1 drained", {25'b0, status[6:0]}, 32'd0);
        strobe(1, 32'h0);
        chk("R9 underflow flag", {31'b0, status[15]}, 32'h1);
        chk("R9 overflow sticky", {31'b0, status[14]}, 32'h1);

        // R6 flush
        strobe(0, 32'h1); strobe(0, 32'h2);
        strobe(5, 32'h0001_0000);
        chk("R6 flush empties", {25'b0, status[6:0]}, 32'd0);
        chk("R6 flush clears errors", {30'b0, status[15:14]}, 32'h0);

        // R4 last data flag
        strobe(4, 32'h0);
        chk("R4 last set", {31'b0, status[9]}, 32'h1);
        int_mask = 3'b010; #1;
        chk("R7 last irq", {31'b0, irq}, 32'h1);
        strobe(5, 32'h0000_0080);
        chk("R4 write without bit9 keeps flag", {31'b0, status[9]}, 32'h1);
        strobe(5, 32'h0000_0200);
        chk("R4 write-1 clears", {31'b0, status[9]}, 32'h0);
        chk("R7 irq drops after clear", {31'b0, irq}, 32'h0);
        int_mask = 3'b000;

        // Transmit side: R3, R5, R7, R10
        dir_tx = 1'b1; #1;
        chk("R3 tx ready empty", {31'b0, status[13]}, 32'h1);
        chk("R5 no pending empty", {31'b0, status[10]}, 32'h0);
        chk("R7 tx half empty flag", {31'b0, status[8]}, 32'h1);
        int_mask = 3'b100; #1;
        chk("R7 tx half empty irq", {31'b0, irq}, 32'h1);
        for (int i = 0; i < 8; i++) strobe(2, 32'h200 + i);
        chk("R7 eight words still half empty", {31'b0, status[8]}, 32'h1);
        strobe(2, 32'h208);
        chk("R7 nine words not half empty", {31'b0, status[8]}, 32'h0);
        chk("R7 irq off at nine", {31'b0, irq}, 32'h0);
        chk("R5 pending", {31'b0, status[10]}, 32'h1);
        for (int i = 9; i < 16; i++) strobe(2, 32'h200 + i);
        chk("R3 tx ready off when full", {31'b0, status[13]}, 32'h0);
        strobe(4, 32'h0);
        chk("R10 end pulse ignored in tx", {31'b0, status[9]}, 32'h0);
        strobe(1, 32'h0);
        chk("R10 bus pop ignored in tx", {25'b0, status[6:0]}, 32'd64);
        chk("R8 tx head", ser_pop_data, 32'h200);
        strobe(3, 32'h0);
        chk("R8 tx next head", ser_pop_data, 32'h201);
        int_mask = 3'b000;
        strobe(5, 32'h0001_0000);
        chk("R5 pending clear after flush", {31'b0, status[10]}, 32'h0);

        $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule